// File: doc/BRIEF.md
# Contiguous Range Page-Table Entry Generator

This block turns a single mapping request into the stream of 64-bit page-table entry writes that cover it. The request gives a virtual page position, a physical entry word that already holds the frame address and the attribute bits, and a length in 4 KiB pages. The generator splits the range into naturally aligned blocks of 2^level pages. It emits one entry per page and stamps every entry with the block's contiguity level, so that a later translator can treat the whole block as one larger page. Each write carries a directory index, a table index and the 64-bit data word.

Before each block the generator asks the caller whether the directory slot for the current page exists. The caller answers combinationally on `dir_present` for the index it sees on `look_dir`. If the slot is missing, the generator stalls and raises `dir_fill_req` until the caller acknowledges with the base address of a freshly allocated table. The generator then emits the directory entry for that table and continues. Blocks never cross a table boundary, because the table holds at least 2^MAX_LVL entries and every block is aligned.

The controller is a state machine with six states:
- `ST_IDLE` goes to `ST_LOOKUP` on `start`, or to `ST_FINISH` when the count is zero.
- `ST_LOOKUP` picks the level, then goes to `ST_EMIT` when the slot is present and to `ST_WAIT_SLOT` when it is not.
- `ST_WAIT_SLOT` goes to `ST_SLOT_WR` on `dir_fill_ack`.
- `ST_SLOT_WR` always goes on to `ST_EMIT`.
- `ST_EMIT` stays put until the block's last entry. It then returns to `ST_LOOKUP`, or goes to `ST_FINISH` if that block used up the count.
- `ST_FINISH` always returns to `ST_IDLE`.

Top module: `pte_range_gen`

## Requirements
- R1: While reset is asserted and at the first cycle after it, `busy`, `done`, `wr_valid`, `dir_fill_req` and `pde_valid` are low.
- R2: `start` in idle captures the request. The page number is `virt_off` (byte-offset bits from PAGE_SHIFT upward). Each entry's `wr_dir` is its page number divided by TBL_ENTRIES, and its `wr_tbl` is the remainder.
- R3: The level of a block starts at 0. It grows by one while it is below MAX_LVL, the remaining page count is at least 2^(level+1), and bit `level` of the current page number is 0. The first entry of a block therefore has a table index aligned to 2^level.
- R4: A block emits 2^level entries on consecutive cycles. They have consecutive table indices and identical data and level.
- R5: After a block, the page number grows by 2^level, the physical word grows by 4096·2^level, and the remaining count shrinks by 2^level. The next block follows after one lookup cycle.
- R6: Entry data is `phys_word` (advanced per R5) ORed with the level placed at bits 9:7. All other bits pass unchanged, including the present bit 0 and the tile attributes in bits 63:40.
- R7: `done` pulses for one cycle, in the cycle after the last entry, and `busy` is low in the cycle after that. A zero count gives `done` in the cycle after `start`, with no entry written.
- R8: When `dir_present` is low in the lookup cycle, `dir_fill_req` rises and stays high. No entry is written until `dir_fill_ack` is seen.
- R9: An acknowledge in the wait state is followed by one cycle of `pde_valid`. In that cycle `pde_data` is `dir_fill_base` ORed with 3 and `pde_dir` is the slot index. Entry writes start in the next cycle.
- R10: `start` while busy is ignored, and the running request's entries are unchanged.
- R11: `dir_fill_ack` outside the wait state is ignored: it produces no `pde_valid` and no `dir_fill_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a request (idle only) |
| virt_off | input | VA_W-PAGE_SHIFT | Virtual byte-offset bits above the page size |
| phys_word | input | 64 | Physical entry word with attribute bits |
| page_count | input | CNT_W | Number of 4 KiB pages to map |
| dir_present | input | 1 | Caller's answer: slot at `look_dir` exists |
| dir_fill_ack | input | 1 | Caller filled the missing slot |
| dir_fill_base | input | 64 | Base address of the new table |
| look_dir | output | DIR_W | Directory index being looked up |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| dir_fill_req | output | 1 | Missing directory slot, stalled |
| wr_valid | output | 1 | Entry write this cycle |
| wr_dir | output | DIR_W | Directory index of entry |
| wr_tbl | output | TBL_W | Table index of entry |
| wr_data | output | 64 | Entry data word |
| wr_level | output | LVL_W | Contiguity level of entry |
| pde_valid | output | 1 | Directory entry write this cycle |
| pde_dir | output | DIR_W | Directory index being written |
| pde_data | output | 64 | Directory entry word |

## Verification
The bench builds the block with a 28-bit address, 128-entry tables and a 12-bit count. This keeps the directory at 512 slots, so the bench can model slot presence completely. The small table also means random ranges often cross directory boundaries and trigger fills. The default MAX_LVL of 7 equals the table's alignment span. Both full 128-page blocks and the boundary where the level stops growing therefore come within reach of short runs.

// File: rtl/pte_gen_pkg.sv
package pte_gen_pkg;

    localparam int PHYS_W  = 64;
    localparam int LVL_LSB = 7;
    localparam logic [1:0] PDE_FLAGS = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WAIT_SLOT,
        ST_SLOT_WR,
        ST_EMIT,
        ST_FINISH
    } gen_state_t;

endpackage

// File: rtl/pte_lvl_pick.sv
// Chooses the contiguity level of the next block from the low page bits
// and the remaining page count.
module pte_lvl_pick #(
    parameter int MAX_LVL = 7,
    parameter int CNT_W   = 20,
    parameter int LVL_W   = 3
) (
    input  logic [MAX_LVL-1:0] page_lo,
    input  logic [CNT_W-1:0]   remaining,
    output logic [LVL_W-1:0]   lvl
);

    logic [MAX_LVL:0] grow_ok;

    assign grow_ok[0] = 1'b1;

    generate
        for (genvar j = 0; j < MAX_LVL; j++) begin : g_step
            assign grow_ok[j+1] = grow_ok[j]
                               && ((remaining >> (j + 1)) != '0)
                               && !page_lo[j];
        end
    endgenerate

    always_comb begin
        lvl = '0;
        for (int k = 1; k <= MAX_LVL; k++) begin
            if (grow_ok[k]) lvl = LVL_W'(k);
        end
    end

endmodule

// File: rtl/pte_word_fmt.sv
// Forms the entry word (level stamped in) and the directory word.
module pte_word_fmt #(
    parameter int LVL_W = 3
) (
    input  logic [pte_gen_pkg::PHYS_W-1:0] phys,
    input  logic [LVL_W-1:0]               lvl,
    input  logic [pte_gen_pkg::PHYS_W-1:0] tbl_base,
    output logic [pte_gen_pkg::PHYS_W-1:0] pte,
    output logic [pte_gen_pkg::PHYS_W-1:0] pde
);
    import pte_gen_pkg::*;

    assign pte = phys | (PHYS_W'(lvl) << LVL_LSB);
    assign pde = tbl_base | PHYS_W'(PDE_FLAGS);

endmodule

// File: rtl/pte_range_gen.sv
module pte_range_gen #(
    parameter int VA_W        = 40,
    parameter int PAGE_SHIFT  = 12,
    parameter int TBL_ENTRIES = 512,
    parameter int MAX_LVL     = 7,
    parameter int CNT_W       = 20,
    localparam int PG_W   = VA_W - PAGE_SHIFT,
    localparam int TBL_W  = $clog2(TBL_ENTRIES),
    localparam int DIR_W  = PG_W - TBL_W,
    localparam int LVL_W  = $clog2(MAX_LVL + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [VA_W-1:PAGE_SHIFT] virt_off,
    input  logic [63:0]           phys_word,
    input  logic [CNT_W-1:0]      page_count,
    input  logic                  dir_present,
    input  logic                  dir_fill_ack,
    input  logic [63:0]           dir_fill_base,
    output logic [DIR_W-1:0]      look_dir,
    output logic                  busy,
    output logic                  done,
    output logic                  dir_fill_req,
    output logic                  wr_valid,
    output logic [DIR_W-1:0]      wr_dir,
    output logic [TBL_W-1:0]      wr_tbl,
    output logic [63:0]           wr_data,
    output logic [LVL_W-1:0]      wr_level,
    output logic                  pde_valid,
    output logic [DIR_W-1:0]      pde_dir,
    output logic [63:0]           pde_data
);
    import pte_gen_pkg::*;

    localparam int CW = MAX_LVL + 1;

    gen_state_t state_q, state_d;

    logic [PG_W-1:0]    page_q;
    logic [PHYS_W-1:0]  phys_q;
    logic [CNT_W-1:0]   rem_q;
    logic [LVL_W-1:0]   lvl_q;
    logic [MAX_LVL-1:0] cnt_q;
    logic [PHYS_W-1:0]  base_q;

    logic [LVL_W-1:0]   lvl_next;
    logic [CNT_W-1:0]   blk_len;
    logic [CW-1:0]      blk_span;
    logic [MAX_LVL-1:0] blk_last;
    logic [PHYS_W-1:0]  phys_step;
    logic               last_entry;
    logic [PHYS_W-1:0]  pte_word;
    logic [PHYS_W-1:0]  pde_word;

    // level of the block that starts at the current page
    pte_lvl_pick #(
        .MAX_LVL (MAX_LVL),
        .CNT_W   (CNT_W),
        .LVL_W   (LVL_W)
    ) u_lvl (
        .page_lo   (page_q[MAX_LVL-1:0]),
        .remaining (rem_q),
        .lvl       (lvl_next)
    );

    pte_word_fmt #(
        .LVL_W (LVL_W)
    ) u_fmt (
        .phys     (phys_q),
        .lvl      (lvl_q),
        .tbl_base (base_q),
        .pte      (pte_word),
        .pde      (pde_word)
    );

    assign blk_len    = CNT_W'(1) << lvl_q;
    assign blk_span   = (CW'(1) << lvl_q) - CW'(1);
    assign blk_last   = blk_span[MAX_LVL-1:0];
    assign phys_step  = PHYS_W'(1) << (PAGE_SHIFT + int'(lvl_q));
    assign last_entry = (cnt_q == blk_last);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = (page_count == '0) ? ST_FINISH : ST_LOOKUP;
            end
            ST_LOOKUP: begin
                state_d = dir_present ? ST_EMIT : ST_WAIT_SLOT;
            end
            ST_WAIT_SLOT: begin
                if (dir_fill_ack) state_d = ST_SLOT_WR;
            end
            ST_SLOT_WR: begin
                state_d = ST_EMIT;
            end
            ST_EMIT: begin
                if (last_entry) state_d = (rem_q == blk_len) ? ST_FINISH : ST_LOOKUP;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // request datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            phys_q <= '0;
            rem_q  <= '0;
            lvl_q  <= '0;
            cnt_q  <= '0;
            base_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        page_q <= virt_off;
                        phys_q <= phys_word;
                        rem_q  <= page_count;
                    end
                end
                ST_LOOKUP: begin
                    lvl_q <= lvl_next;
                    cnt_q <= '0;
                end
                ST_WAIT_SLOT: begin
                    if (dir_fill_ack) base_q <= dir_fill_base;
                end
                ST_EMIT: begin
                    cnt_q <= cnt_q + MAX_LVL'(1);
                    if (last_entry) begin
                        page_q <= page_q + PG_W'(blk_len);
                        phys_q <= phys_q + phys_step;
                        rem_q  <= rem_q - blk_len;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        look_dir     = page_q[PG_W-1:TBL_W];
        busy         = (state_q != ST_IDLE);
        done         = (state_q == ST_FINISH);
        dir_fill_req = (state_q == ST_WAIT_SLOT);
        wr_valid     = (state_q == ST_EMIT);
        wr_dir       = page_q[PG_W-1:TBL_W];
        wr_tbl       = page_q[TBL_W-1:0] | TBL_W'(cnt_q);
        wr_data      = pte_word;
        wr_level     = lvl_q;
        pde_valid    = (state_q == ST_SLOT_WR);
        pde_dir      = page_q[PG_W-1:TBL_W];
        pde_data     = pde_word;
    end

endmodule

// File: rtl/pte_range_gen_chk.sv
module pte_range_gen_chk #(
    parameter int TBL_W = 9,
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             dir_fill_req,
    input logic             dir_fill_ack,
    input logic             wr_valid,
    input logic [TBL_W-1:0] wr_tbl,
    input logic [63:0]      wr_data,
    input logic [LVL_W-1:0] wr_level,
    input logic             pde_valid
);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_fill_req && !dir_fill_ack |=> dir_fill_req);

    // R8
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_fill_req |-> !wr_valid);

    // R9
    slot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_fill_req && dir_fill_ack |=> pde_valid);

    // R9
    entry_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pde_valid |=> wr_valid);

    // R4
    block_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && $past(wr_valid) |->
            $stable(wr_data) && $stable(wr_level)
            && (wr_tbl == TBL_W'($past(wr_tbl) + TBL_W'(1))));

    // R3
    block_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !$past(wr_valid) |->
            ((wr_tbl & ((TBL_W'(1) << wr_level) - TBL_W'(1))) == '0));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_valid && !dir_fill_req && !pde_valid);

endmodule

bind pte_range_gen pte_range_gen_chk #(
    .TBL_W (TBL_W),
    .LVL_W (LVL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (done),
    .dir_fill_req (dir_fill_req),
    .dir_fill_ack (dir_fill_ack),
    .wr_valid     (wr_valid),
    .wr_tbl       (wr_tbl),
    .wr_data      (wr_data),
    .wr_level     (wr_level),
    .pde_valid    (pde_valid)
);

// File: tb/sim_pte_range_gen.sv
module sim_pte_range_gen;

    localparam int VA_W    = 28;
    localparam int PSH     = 12;
    localparam int TBL_E   = 128;
    localparam int MAX_LVL = 7;
    localparam int CNT_W   = 12;
    localparam int PG_W    = VA_W - PSH;
    localparam int TBL_W   = 7;
    localparam int DIR_W   = PG_W - TBL_W;
    localparam int LVL_W   = 3;
    localparam int STRAY_AT = 50;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [VA_W-1:PSH]    virt_off = '0;
    logic [63:0]          phys_word = '0;
    logic [CNT_W-1:0]     page_count = '0;
    logic                 dir_present;
    logic                 dir_fill_ack = 1'b0;
    logic [63:0]          dir_fill_base = '0;
    logic [DIR_W-1:0]     look_dir;
    logic                 busy, done, dir_fill_req, wr_valid, pde_valid;
    logic [DIR_W-1:0]     wr_dir, pde_dir;
    logic [TBL_W-1:0]     wr_tbl;
    logic [63:0]          wr_data, pde_data;
    logic [LVL_W-1:0]     wr_level;

    pte_range_gen #(
        .VA_W (VA_W), .PAGE_SHIFT (PSH), .TBL_ENTRIES (TBL_E),
        .MAX_LVL (MAX_LVL), .CNT_W (CNT_W)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .start (start), .virt_off (virt_off),
        .phys_word (phys_word), .page_count (page_count),
        .dir_present (dir_present), .dir_fill_ack (dir_fill_ack),
        .dir_fill_base (dir_fill_base), .look_dir (look_dir), .busy (busy),
        .done (done), .dir_fill_req (dir_fill_req), .wr_valid (wr_valid),
        .wr_dir (wr_dir), .wr_tbl (wr_tbl), .wr_data (wr_data),
        .wr_level (wr_level), .pde_valid (pde_valid), .pde_dir (pde_dir),
        .pde_data (pde_data)
    );

    bit pres [0:(1<<DIR_W)-1];
    assign dir_present = pres[look_dir];

    int n_chk = 0;
    int n_bad = 0;
    int done_cnt = 0;
    int wr_cnt = 0;
    int fill_wait = 0;
    int cyc = 0;
    bit stray_live = 1'b0;
    logic [63:0] last_base = '0;
    logic [DIR_W-1:0] req_dir = '0;

    logic [DIR_W-1:0] q_dir [$];
    logic [TBL_W-1:0] q_tbl [$];
    logic [63:0]      q_data [$];
    logic [LVL_W-1:0] q_lvl [$];

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int pick_lvl(input int pg, input int rem);
        int l = 0;
        while (l < MAX_LVL && rem >= (2 << l) && ((pg >> l) & 1) == 0) l++;
        return l;
    endfunction

    // expected entries from the requirements (R2..R6)
    task automatic plan_run(input int pg, input logic [63:0] ph, input int n);
        int l;
        while (n > 0) begin
            l = pick_lvl(pg, n);
            for (int i = 0; i < (1 << l); i++) begin
                q_dir.push_back(DIR_W'((pg + i) / TBL_E));
                q_tbl.push_back(TBL_W'((pg + i) % TBL_E));
                q_data.push_back(ph | (64'(l) << 7));
                q_lvl.push_back(LVL_W'(l));
            end
            pg += (1 << l);
            ph += 64'(1) << (PSH + l);
            n  -= (1 << l);
        end
    endtask

    // monitor and slot responder
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid) begin
                wr_cnt++;
                if (q_data.size() == 0) begin
                    chk(1'b0, "R7 unexpected entry", 64'(wr_tbl), 64'hx);
                end else begin
                    chk(wr_dir == q_dir[0], "R2 dir index", 64'(wr_dir), 64'(q_dir[0]));
                    chk(wr_tbl == q_tbl[0], "R2 table index", 64'(wr_tbl), 64'(q_tbl[0]));
                    chk(wr_data == q_data[0], "R5/R6 entry data", wr_data, q_data[0]);
                    chk(wr_level == q_lvl[0], "R3/R4 level", 64'(wr_level), 64'(q_lvl[0]));
                    void'(q_dir.pop_front());
                    void'(q_tbl.pop_front());
                    void'(q_data.pop_front());
                    void'(q_lvl.pop_front());
                end
                chk(pres[wr_dir], "R8 entry into absent slot", 64'(wr_dir), 64'h1);
            end
            if (pde_valid) begin
                chk(pde_data == (last_base | 64'h3), "R9 slot word", pde_data, last_base | 64'h3);
                chk(pde_dir == req_dir, "R9 slot index", 64'(pde_dir), 64'(req_dir));
                pres[pde_dir] = 1'b1;
            end
            if (done) begin
                done_cnt++;
                chk(q_data.size() == 0, "R7 entries left at done", 64'(q_data.size()), 64'h0);
            end
            if (stray_live) begin
                chk(!pde_valid && !dir_fill_req, "R11 stray ack",
                    64'({pde_valid, dir_fill_req}), 64'h0);
                dir_fill_ack = 1'b0;
                stray_live = 1'b0;
            end else if (dir_fill_req) begin
                req_dir = look_dir;
                chk(!wr_valid, "R8 stall", 64'(wr_valid), 64'h0);
                if (!dir_fill_ack) begin
                    if (fill_wait == 0) begin
                        last_base = {$urandom, $urandom} & ~64'hFFF;
                        dir_fill_base = last_base;
                        dir_fill_ack = 1'b1;
                    end else begin
                        fill_wait--;
                    end
                end
            end else if (dir_fill_ack) begin
                dir_fill_ack = 1'b0;
                fill_wait = $urandom % 4;
            end else if (wr_valid && wr_cnt == STRAY_AT) begin
                dir_fill_ack = 1'b1;
                dir_fill_base = '1;
                stray_live = 1'b1;
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL R7 watchdog actual=%0d expected=<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic do_run(input int pg, input logic [63:0] ph, input int n,
                          input bit poke);
        int d0;
        int w0;
        plan_run(pg, ph, n);
        d0 = done_cnt;
        w0 = wr_cnt;
        virt_off   = PG_W'(pg);
        phys_word  = ph;
        page_count = CNT_W'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            virt_off   = PG_W'(pg + 9);
            phys_word  = ~ph;
            page_count = CNT_W'(3);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy, "R10 busy after ignored start", 64'(busy), 64'h1);
        end
        while (done_cnt == d0) @(negedge clk);
        chk(wr_cnt - w0 == n, "R10 entry count", 64'(wr_cnt - w0), 64'(n));
        @(negedge clk);
        chk(!busy, "R7 idle after done", 64'(busy), 64'h0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < (1 << DIR_W); i++) pres[i] = ($urandom % 2) == 1;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !wr_valid && !dir_fill_req && !pde_valid, "R1 reset state",
            64'({busy, done, wr_valid, dir_fill_req, pde_valid}), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !wr_valid, "R1 after release",
            64'({busy, done, wr_valid}), 64'h0);

        // zero count
        virt_off = PG_W'(77);
        page_count = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done && !wr_valid, "R7 zero count done", 64'({done, wr_valid}), 64'h2);
        @(negedge clk);
        chk(!busy, "R7 zero count idle", 64'(busy), 64'h0);

        // full aligned block at level 7 (stray ack lands inside it)
        do_run(0, 64'h0000_AB00_0000_1001, 128, 1'b0);
        // single page, odd position
        do_run(3, 64'h0000_0100_0020_0001, 1, 1'b0);
        // misaligned start, levels grow then shrink
        do_run(1, 64'h00FF_0000_0004_0001, 20, 1'b0);
        // crosses a directory boundary
        do_run(120, 64'h0012_0000_0800_0001, 20, 1'b0);
        // forced missing slot
        pres[256] = 1'b0;
        do_run(256 * TBL_E, 64'h0000_0000_1234_5001, 5, 1'b0);
        // ignored start while busy
        do_run(1000, 64'h0003_0000_0000_0001, 200, 1'b1);
        // top of the range, one short of max level growth
        do_run((1 << PG_W) - 127, 64'h0000_0000_0000_0001, 127, 1'b0);

        for (int r = 0; r < 40; r++) begin
            int n;
            int pg;
            n  = 1 + ($urandom % 300);
            pg = $urandom % ((1 << PG_W) - n);
            if (r % 5 == 0) pg = pg & ~127;
            do_run(pg, {$urandom, $urandom}, n, 1'b0);
        end

        summary();
        $finish;
    end

endmodule